// File: doc/BRIEF.md
# Branch Condition and Loop Evaluator

This block resolves the outcome of 16-bit conditional relative branches, count-register tests, counted loops and the trap-on-overflow operation. Each request arrives with a valid strobe and carries a condition select code, the four arithmetic status flags (carry, zero, sign, overflow), the 16-bit count register, the current instruction pointer and an 8-bit signed displacement.

One clock later the block presents a registered result: whether the branch is taken, the next instruction pointer, the count register value to write back and, for the trap operation, an interrupt request with its vector number. Fetch, decode and the interrupt entry sequence are done elsewhere; this block only reports which vector should be raised.

Top module: `branch_eval`

## Requirements
- R1: Results appear on the outputs one clock after a cycle with `in_valid` high, with `out_valid` high for exactly that cycle; in a cycle after `in_valid` low, `out_valid` is low and all other outputs keep their previous values.
- R2: Flag conditions (select code: taken when) are 0: OF=1; 1: OF=0; 2: CF=1; 3: CF=0; 4: ZF=1; 5: ZF=0; 6: CF=1 or ZF=1; 7: CF=0 and ZF=0; 8: SF=1; 9: SF=0; 10: SF!=OF; 11: SF==OF; 12: ZF=1 or SF!=OF; 13: ZF=0 and SF==OF. These never change the count register.
- R3: Select 16 (count-zero test) is taken exactly when the count input is 0, and the count output equals the count input.
- R4: Select 17 (loop) first decrements the count modulo 2^16, then is taken exactly when the decremented value is nonzero; a count of 0 becomes 0xFFFF and is taken, a count of 1 becomes 0 and is not taken.
- R5: Select 18 (loop while equal) and select 19 (loop while not equal) decrement the count like R4 and are taken when the new count is nonzero and ZF is 1 (select 18) or ZF is 0 (select 19).
- R6: A taken branch yields next IP = IP + sign-extended displacement modulo 2^16; a branch not taken yields next IP equal to the input IP.
- R7: Select 20 (trap on overflow) raises `irq_req` with `irq_vector` = 4 when OF=1, and with OF=0 raises nothing; it is never taken and leaves the count unchanged. Whenever `irq_req` is low, `irq_vector` is 0.
- R8: Any other select code (14, 15, 21 to 31) gives not taken, next IP equal to IP, no interrupt and an unchanged count.
- R9: After reset all outputs are 0 until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| cond_sel | input | 5 | Condition select code |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| cx_in | input | 16 | Count register value |
| ip_in | input | 16 | Current instruction pointer |
| disp_in | input | 8 | Signed branch displacement |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| next_ip | output | 16 | Next instruction pointer |
| cx_out | output | 16 | Count register to write back |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Interrupt vector number |

## Verification
Every piece of internal state here is a result register, so a wrong decision, target sum or count update shows up on the ports in the very cycle after the strobe. A held register that is overwritten during an idle cycle shows up in that idle cycle as a changed output with `out_valid` low. The loop decrement at 0 and 1, displacement extremes 0x7F and 0x80, and instruction pointer wrap at 0xFFFF are driven explicitly, alongside a long mixed stream with idle gaps.

// File: rtl/bre_pkg.sv
package bre_pkg;

    localparam int SEL_W = 5;

    typedef enum logic [SEL_W-1:0] {
        SEL_OVF      = 5'd0,
        SEL_NOVF     = 5'd1,
        SEL_CARRY    = 5'd2,
        SEL_NCARRY   = 5'd3,
        SEL_ZERO     = 5'd4,
        SEL_NZERO    = 5'd5,
        SEL_BELOW_EQ = 5'd6,
        SEL_ABOVE    = 5'd7,
        SEL_SIGN     = 5'd8,
        SEL_NSIGN    = 5'd9,
        SEL_LESS     = 5'd10,
        SEL_GE       = 5'd11,
        SEL_LE       = 5'd12,
        SEL_GT       = 5'd13,
        SEL_CNT_ZERO = 5'd16,
        SEL_LOOP     = 5'd17,
        SEL_LOOP_EQ  = 5'd18,
        SEL_LOOP_NE  = 5'd19,
        SEL_TRAP_OV  = 5'd20
    } sel_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
    } flags_t;

endpackage

// File: rtl/bre_flag_cond.sv
module bre_flag_cond
    import bre_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  flags_t           flags,
    output logic             hit,
    output logic             is_flag_sel
);

    logic sign_ne_ovf;
    logic base;
    logic invert;

    assign sign_ne_ovf = flags.sf ^ flags.of;

    // Conditions come in pairs: even code tests a base term, odd code its negation.
    always_comb begin
        base        = 1'b0;
        is_flag_sel = (sel <= SEL_W'(13));
        invert      = sel[0];
        unique case (sel[SEL_W-1:1])
            4'd0:    base = flags.of;
            4'd1:    base = flags.cf;
            4'd2:    base = flags.zf;
            4'd3:    base = flags.cf | flags.zf;
            4'd4:    base = flags.sf;
            4'd5:    base = sign_ne_ovf;
            4'd6:    base = flags.zf | sign_ne_ovf;
            default: base = 1'b0;
        endcase
        hit = is_flag_sel & (base ^ invert);
    end

endmodule

// File: rtl/bre_count_unit.sv
module bre_count_unit
    import bre_pkg::*;
#(
    parameter int CX_W = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [CX_W-1:0]  cx,
    input  logic             zf,
    output logic [CX_W-1:0]  cx_next,
    output logic             hit
);

    logic [CX_W-1:0] cx_dec;
    logic            dec_nz;

    assign cx_dec = cx - CX_W'(1);
    assign dec_nz = |cx_dec;

    always_comb begin
        cx_next = cx;
        hit     = 1'b0;
        case (sel_e'(sel))
            SEL_CNT_ZERO: hit = ~|cx;
            SEL_LOOP: begin
                cx_next = cx_dec;
                hit     = dec_nz;
            end
            SEL_LOOP_EQ: begin
                cx_next = cx_dec;
                hit     = dec_nz & zf;
            end
            SEL_LOOP_NE: begin
                cx_next = cx_dec;
                hit     = dec_nz & ~zf;
            end
            default: begin
                cx_next = cx;
                hit     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bre_target.sv
module bre_target #(
    parameter int IP_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [IP_W-1:0]   ip,
    input  logic [DISP_W-1:0] disp,
    output logic [IP_W-1:0]   target
);

    localparam int EXT_W = IP_W - DISP_W;

    logic [IP_W-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[IP_W-1:0];
        end
    endgenerate

    assign target = ip + disp_ext;

endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import bre_pkg::*;
#(
    parameter int IP_W     = 16,
    parameter int CX_W     = 16,
    parameter int DISP_W   = 8,
    parameter int VEC_W    = 8,
    parameter int TRAP_VEC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic              flag_cf,
    input  logic              flag_zf,
    input  logic              flag_sf,
    input  logic              flag_of,
    input  logic [CX_W-1:0]   cx_in,
    input  logic [IP_W-1:0]   ip_in,
    input  logic [DISP_W-1:0] disp_in,
    output logic              out_valid,
    output logic              taken,
    output logic [IP_W-1:0]   next_ip,
    output logic [CX_W-1:0]   cx_out,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector
);

    typedef struct packed {
        logic             valid;
        logic             taken;
        logic [IP_W-1:0]  ip;
        logic [CX_W-1:0]  cx;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } result_t;

    flags_t          flags;
    logic            flag_hit;
    logic            flag_sel;
    logic            count_hit;
    logic [CX_W-1:0] count_cx;
    logic [IP_W-1:0] target;
    logic            trap_sel;
    result_t         res_d;
    result_t         res_q;

    assign flags = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of};

    bre_flag_cond u_flag_cond (
        .sel         (cond_sel),
        .flags       (flags),
        .hit         (flag_hit),
        .is_flag_sel (flag_sel)
    );

    bre_count_unit #(.CX_W(CX_W)) u_count (
        .sel     (cond_sel),
        .cx      (cx_in),
        .zf      (flag_zf),
        .cx_next (count_cx),
        .hit     (count_hit)
    );

    bre_target #(.IP_W(IP_W), .DISP_W(DISP_W)) u_target (
        .ip     (ip_in),
        .disp   (disp_in),
        .target (target)
    );

    assign trap_sel = (cond_sel == SEL_TRAP_OV);

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            res_d.taken = flag_hit | count_hit;
            res_d.ip    = res_d.taken ? target : ip_in;
            res_d.cx    = count_cx;
            res_d.irq   = trap_sel & flag_of;
            res_d.vec   = res_d.irq ? VEC_W'(TRAP_VEC) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.valid;
    assign taken      = res_q.taken;
    assign next_ip    = res_q.ip;
    assign cx_out     = res_q.cx;
    assign irq_req    = res_q.irq;
    assign irq_vector = res_q.vec;

endmodule

// File: rtl/bre_checker.sv
module bre_checker
    import bre_pkg::*;
#(
    parameter int IP_W     = 16,
    parameter int CX_W     = 16,
    parameter int VEC_W    = 8,
    parameter int TRAP_VEC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SEL_W-1:0] cond_sel,
    input logic             flag_of,
    input logic [CX_W-1:0]  cx_in,
    input logic [IP_W-1:0]  ip_in,
    input logic             out_valid,
    input logic             taken,
    input logic [IP_W-1:0]  next_ip,
    input logic [CX_W-1:0]  cx_out,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vector
);

    // R1
    strobe_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(taken) && $stable(next_ip) && $stable(cx_out) && $stable(irq_req)));

    // R6
    not_taken_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || next_ip == $past(ip_in)));

    // R3
    cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == SEL_CNT_ZERO) |=> (cx_out == $past(cx_in) && taken == ($past(cx_in) == '0)));

    // R4
    loop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == SEL_LOOP) |=> (cx_out == $past(cx_in) - CX_W'(1) && taken == (cx_out != '0)));

    // R7
    trap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector == VEC_W'(TRAP_VEC) && !taken));

    // R7
    trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == SEL_TRAP_OV) |=> (irq_req == $past(flag_of) && cx_out == $past(cx_in)));

    // R8
    unknown_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cond_sel == 5'd14 || cond_sel == 5'd15 || cond_sel > 5'd20))
        |=> (!taken && !irq_req && cx_out == $past(cx_in)));

endmodule

bind branch_eval bre_checker #(
    .IP_W(IP_W), .CX_W(CX_W), .VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)
) u_bre_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .cond_sel   (cond_sel),
    .flag_of    (flag_of),
    .cx_in      (cx_in),
    .ip_in      (ip_in),
    .out_valid  (out_valid),
    .taken      (taken),
    .next_ip    (next_ip),
    .cx_out     (cx_out),
    .irq_req    (irq_req),
    .irq_vector (irq_vector)
);

// File: tb/test_branch_eval.sv
module test_branch_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  cond_sel = '0;
    logic        flag_cf = 1'b0, flag_zf = 1'b0, flag_sf = 1'b0, flag_of = 1'b0;
    logic [15:0] cx_in = '0, ip_in = '0;
    logic [7:0]  disp_in = '0;
    logic        out_valid, taken, irq_req;
    logic [15:0] next_ip, cx_out;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference expectation (what the outputs must show after the next edge)
    int    e_valid = 0, e_taken = 0, e_ip = 0, e_cx = 0, e_irq = 0, e_vec = 0;
    string e_tag = "R9";

    always #2 clk = ~clk;

    branch_eval i_branch_eval (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_sel(cond_sel),
        .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of),
        .cx_in(cx_in), .ip_in(ip_in), .disp_in(disp_in),
        .out_valid(out_valid), .taken(taken), .next_ip(next_ip), .cx_out(cx_out),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    function automatic string tag_of(int s);
        if (s <= 13) return "R2";
        if (s == 16) return "R3";
        if (s == 17) return "R4";
        if (s == 18 || s == 19) return "R5";
        if (s == 20) return "R7";
        return "R8";
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== 1'(e_valid) || taken !== 1'(e_taken) || next_ip !== 16'(e_ip) ||
            cx_out !== 16'(e_cx) || irq_req !== 1'(e_irq) || irq_vector !== 8'(e_vec)) begin
            errors++;
            $display("FAIL %s act v=%0d t=%0d ip=%h cx=%h irq=%0d vec=%0d exp v=%0d t=%0d ip=%h cx=%h irq=%0d vec=%0d",
                     e_tag, out_valid, taken, next_ip, cx_out, irq_req, irq_vector,
                     e_valid, e_taken, 16'(e_ip), 16'(e_cx), e_irq, e_vec);
        end
    endtask

    // one cycle: check what the previous cycle produced, then drive new inputs
    task automatic step(bit v, int s, bit cf, bit zf, bit sf, bit of, int cx, int ip, int d);
        int  cond;
        int  dext;
        int  ncx;
        @(negedge clk);
        compare();
        in_valid = v; cond_sel = 5'(s);
        flag_cf = cf; flag_zf = zf; flag_sf = sf; flag_of = of;
        cx_in = 16'(cx); ip_in = 16'(ip); disp_in = 8'(d);
        e_valid = v;
        if (!v) begin
            e_tag = "R1";
            return;
        end
        cond = 0; ncx = cx & 16'hFFFF;
        case (s)
            0: cond = of;            1: cond = !of;
            2: cond = cf;            3: cond = !cf;
            4: cond = zf;            5: cond = !zf;
            6: cond = cf || zf;      7: cond = !cf && !zf;
            8: cond = sf;            9: cond = !sf;
            10: cond = sf != of;     11: cond = sf == of;
            12: cond = zf || (sf != of);
            13: cond = !zf && (sf == of);
            16: cond = (ncx == 0);
            17: begin ncx = (ncx + 16'hFFFF) & 16'hFFFF; cond = ncx != 0; end
            18: begin ncx = (ncx + 16'hFFFF) & 16'hFFFF; cond = ncx != 0 && zf; end
            19: begin ncx = (ncx + 16'hFFFF) & 16'hFFFF; cond = ncx != 0 && !zf; end
            default: cond = 0;
        endcase
        dext = (d & 8'hFF) >= 128 ? (d & 8'hFF) - 256 : (d & 8'hFF);
        e_taken = cond;
        e_ip    = cond ? ((ip + dext) & 16'hFFFF) : (ip & 16'hFFFF);
        e_cx    = ncx;
        e_irq   = (s == 20) && of;
        e_vec   = e_irq ? 4 : 0;
        e_tag   = (s != 16 && s != 17 && s <= 19 && cond) ? {tag_of(s), "/R6"} : tag_of(s);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        compare();                       // R9 reset state
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0); // R9 still zero after release
        // R2 all flag conditions, all flag combinations
        for (int s = 0; s <= 13; s++)
            for (int f = 0; f < 16; f++)
                step(1, s, f[0], f[1], f[2], f[3], 16'h1234, 16'h0100, 8'h10);
        // R6 displacement extremes and IP wrap
        step(1, 4, 0, 1, 0, 0, 5, 16'h1000, 8'h7F);
        step(1, 4, 0, 1, 0, 0, 5, 16'h1000, 8'h80);
        step(1, 4, 0, 1, 0, 0, 5, 16'hFFFF, 8'h01);
        step(1, 4, 0, 1, 0, 0, 5, 16'h0000, 8'hFF);
        step(1, 5, 0, 1, 0, 0, 5, 16'h2000, 8'h80);  // not taken keeps IP
        // R3 count-zero test
        step(1, 16, 0, 0, 0, 0, 0, 16'h0300, 8'hF0);
        step(1, 16, 1, 1, 1, 1, 1, 16'h0300, 8'hF0);
        step(1, 16, 0, 0, 0, 0, 16'hFFFF, 16'h0300, 8'hF0);
        // R4 loop corners
        step(1, 17, 0, 0, 0, 0, 0, 16'h0400, 8'hFE);
        step(1, 17, 0, 0, 0, 0, 1, 16'h0400, 8'hFE);
        step(1, 17, 0, 0, 0, 0, 2, 16'h0400, 8'hFE);
        // R5 conditional loops
        for (int z = 0; z < 2; z++) begin
            step(1, 18, 0, z[0], 0, 0, 1, 16'h0500, 8'h08);
            step(1, 18, 0, z[0], 0, 0, 9, 16'h0500, 8'h08);
            step(1, 19, 0, z[0], 0, 0, 1, 16'h0500, 8'h08);
            step(1, 19, 0, z[0], 0, 0, 0, 16'h0500, 8'h08);
        end
        // R7 trap
        step(1, 20, 0, 0, 0, 1, 16'h0042, 16'h0600, 8'h20);
        step(1, 20, 1, 1, 1, 0, 16'h0042, 16'h0600, 8'h20);
        // R1 idle cycles hold the previous result
        step(0, 17, 1, 1, 1, 1, 16'h9999, 16'h7777, 8'h55);
        step(0, 4, 1, 1, 1, 1, 16'h9999, 16'h7777, 8'h55);
        // R8 unknown codes
        for (int s = 14; s < 32; s++)
            if (s == 14 || s == 15 || s > 20)
                step(1, s, 1, 1, 1, 1, 16'h0077, 16'h0800, 8'h04);
        // mixed stream with gaps
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, $urandom % 32, $urandom % 2, $urandom % 2,
                 $urandom % 2, $urandom % 2, ($urandom % 4 == 0) ? ($urandom % 3) : $urandom,
                 $urandom, $urandom);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule